// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures how much of one reference frequency is present in a stream of ADC samples. For each measurement point it multiplies every incoming 12-bit sample by a cosine reference value and by a sine reference value supplied alongside it. It sums the two product streams over a fixed frame of samples.

When the frame is complete, the block reduces the two full-precision sums to 16-bit two's-complement real and imaginary results and pulses a completion flag.

A one-cycle start strobe arms the block and clears both sums and both results. Each sample is then offered with a valid qualifier, together with the cosine and sine values for the same sample index. Samples that are offered while the block is not armed do not affect the sums. The results stay in place until the next start strobe.

Top module: `dft_bin_corr`

## Requirements
- R1: A frame holds exactly FRAME_LEN accepted samples (default 1024). `done_o` rises on the first rising edge after the edge that accepts the final sample, and does not rise earlier in the frame.
- R2: Each sample is centred by subtracting mid-scale. The signed value is code minus 2048, with the 12-bit code read as unsigned. The real sum accumulates centred sample times `cos_i`, and the imaginary sum accumulates centred sample times `sin_i`. Both references are 16-bit signed.
- R3: Each 16-bit result is its full-precision sum shifted arithmetically right by RES_SHIFT bits (default 16, rounding toward minus infinity). The shifted value is then clamped to the range -32768 to 32767.
- R4: `done_o` is high for exactly one cycle per completed frame.
- R5: A start strobe sets `re_o` and `im_o` to 0 on the following edge. Otherwise the results change only on the edge that raises `done_o`.
- R6: A sample offered with `smp_valid_i` high while the block is not armed has no effect on any later result. This covers the time before the first start and the time after a frame completes.
- R7: When `start_i` is high, any sample offered in that cycle is discarded. A start strobe during a frame abandons that frame and begins a new one from zero.
- R8: After reset, `done_o` is 0, both results are 0, and the block is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe: clear and arm |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_code_i | input | 12 | Unsigned ADC code |
| cos_i | input | 16 | Signed cosine reference for this sample |
| sin_i | input | 16 | Signed sine reference for this sample |
| re_o | output | 16 | Real result, two's complement |
| im_o | output | 16 | Imaginary result, two's complement |
| done_o | output | 1 | One-cycle frame-complete pulse |

## Verification
The embedded assertions check the following on every cycle:
- Each sum holds whenever it is neither cleared nor fed.
- A start clears both the sums and the results.
- The results move only on a clear or a load.
- `done_o` is a single-cycle pulse that follows an accepted sample two edges earlier.

The arithmetic needs the bench's frame scenarios: mid-scale centring, product signs, floor shifting and clamping in both directions. The same is true of the exact frame length, the discarding of samples in the start cycle, and the abandoning of a frame by a restart. The bench covers these with frames of constant, ramped, full-scale and small-signal patterns, with and without idle gaps.

// File: rtl/dft_corr_pkg.sv
package dft_corr_pkg;
    localparam int unsigned ADC_W  = 12;
    localparam int unsigned REF_W  = 16;
    localparam int unsigned RES_W  = 16;
    localparam int unsigned SMP_W  = ADC_W + 1;
    localparam int unsigned PROD_W = SMP_W + REF_W;
    localparam int unsigned LANES  = 2;   // lane 0 real (cosine), lane 1 imaginary (sine)

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [REF_W-1:0]  ref_t;
    typedef logic signed [RES_W-1:0]  res_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH
    } ctrl_st_t;

    typedef struct packed {
        logic clr;
        logic en;
        logic load;
    } lane_ctl_t;

    // Offset-binary ADC code to signed value centred on zero
    function automatic smp_t center_code(input logic [ADC_W-1:0] code);
        smp_t raw;
        raw = smp_t'({1'b0, code});
        return raw - smp_t'(1 << (ADC_W - 1));
    endfunction
endpackage

// File: rtl/dft_frame_ctrl.sv
module dft_frame_ctrl
    import dft_corr_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 1024
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      valid_i,
    output lane_ctl_t ctl_o,
    output logic      done_o
);
    localparam int unsigned CNT_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    ctrl_st_t         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    always_comb begin
        ctl_o.clr  = start_i;
        ctl_o.en   = (st_q == ST_RUN) && valid_i && !start_i;
        ctl_o.load = (st_q == ST_FLUSH) && !start_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                st_q  <= ST_RUN;
                cnt_q <= '0;
            end else begin
                case (st_q)
                    ST_RUN: begin
                        if (valid_i) begin
                            if (cnt_q == LAST) begin
                                st_q  <= ST_FLUSH;
                                cnt_q <= '0;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_FLUSH: begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign done_o = done_q;

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    a_r1_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(ctl_o.en, 2));

    a_r6_idle_no_feed: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !ctl_o.en);
endmodule

// File: rtl/dft_mac_lane.sv
module dft_mac_lane
    import dft_corr_pkg::*;
#(
    parameter int unsigned ACC_W = PROD_W + 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_i,
    input  logic                    en_i,
    input  smp_t                    smp_i,
    input  ref_t                    ref_i,
    output logic signed [ACC_W-1:0] acc_o
);
    prod_t                    smp_x;
    prod_t                    ref_x;
    prod_t                    prod;
    logic signed [ACC_W-1:0]  acc_q;

    always_comb begin
        smp_x = PROD_W'(smp_i);
        ref_x = PROD_W'(ref_i);
        prod  = smp_x * ref_x;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= acc_q + ACC_W'(prod);
        end
    end

    assign acc_o = acc_q;

    a_r6_acc_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !en_i) |=> $stable(acc_q));

    a_r7_acc_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (acc_q == '0));
endmodule

// File: rtl/dft_result_reduce.sv
module dft_result_reduce
    import dft_corr_pkg::*;
#(
    parameter int unsigned ACC_W     = PROD_W + 10,
    parameter int unsigned RES_SHIFT = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_i,
    input  logic                    load_i,
    input  logic signed [ACC_W-1:0] acc_i,
    output res_t                    res_o
);
    localparam logic signed [ACC_W-1:0] HI =
        {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LO =
        {{(ACC_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};

    logic signed [ACC_W-1:0] shifted;
    res_t                    clamped;
    res_t                    res_q;

    always_comb begin
        shifted = acc_i >>> RES_SHIFT;
        if (shifted > HI) begin
            clamped = res_t'(HI);
        end else if (shifted < LO) begin
            clamped = res_t'(LO);
        end else begin
            clamped = res_t'(shifted);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            res_q <= '0;
        end else if (load_i) begin
            res_q <= clamped;
        end
    end

    assign res_o = res_q;

    a_r5_res_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !load_i) |=> $stable(res_q));

    a_r5_res_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (res_q == '0));
endmodule

// File: rtl/dft_bin_corr.sv
module dft_bin_corr
    import dft_corr_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 1024,
    parameter int unsigned RES_SHIFT = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    smp_valid_i,
    input  logic [ADC_W-1:0]        smp_code_i,
    input  logic signed [REF_W-1:0] cos_i,
    input  logic signed [REF_W-1:0] sin_i,
    output logic signed [RES_W-1:0] re_o,
    output logic signed [RES_W-1:0] im_o,
    output logic                    done_o
);
    localparam int unsigned ACC_W = PROD_W + $clog2(FRAME_LEN);

    lane_ctl_t          ctl;
    smp_t               smp_c;
    ref_t [LANES-1:0]   refs;
    res_t [LANES-1:0]   res;

    assign smp_c   = center_code(smp_code_i);
    assign refs[0] = cos_i;
    assign refs[1] = sin_i;

    dft_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .valid_i (smp_valid_i),
        .ctl_o   (ctl),
        .done_o  (done_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [ACC_W-1:0] acc;

        dft_mac_lane #(.ACC_W(ACC_W)) u_mac (
            .clk   (clk),
            .rst   (rst),
            .clr_i (ctl.clr),
            .en_i  (ctl.en),
            .smp_i (smp_c),
            .ref_i (refs[g]),
            .acc_o (acc)
        );

        dft_result_reduce #(.ACC_W(ACC_W), .RES_SHIFT(RES_SHIFT)) u_red (
            .clk    (clk),
            .rst    (rst),
            .clr_i  (ctl.clr),
            .load_i (ctl.load),
            .acc_i  (acc),
            .res_o  (res[g])
        );
    end

    assign re_o = res[0];
    assign im_o = res[1];

    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done_o && re_o == '0 && im_o == '0));
endmodule

// File: tb/test_dft_bin_corr.sv
module test_dft_bin_corr;
    localparam int FRAME_LEN = 1024;
    localparam int RES_SHIFT = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start_i = 1'b0;
    logic               smp_valid_i = 1'b0;
    logic [11:0]        smp_code_i = '0;
    logic signed [15:0] cos_i = '0;
    logic signed [15:0] sin_i = '0;
    logic signed [15:0] re_o;
    logic signed [15:0] im_o;
    logic               done_o;

    int checks = 0;
    int fails  = 0;
    longint sum_re, sum_im;
    longint exp_re, exp_im;
    logic early_done;

    always #5 clk = ~clk;

    dft_bin_corr #(.FRAME_LEN(FRAME_LEN), .RES_SHIFT(RES_SHIFT)) i_dft_bin_corr (
        .clk(clk), .rst(rst), .start_i(start_i), .smp_valid_i(smp_valid_i),
        .smp_code_i(smp_code_i), .cos_i(cos_i), .sin_i(sin_i),
        .re_o(re_o), .im_o(im_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic longint reduce(input longint s);
        longint v;
        v = s >>> RES_SHIFT;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    function automatic logic [11:0] pat_code(input int p, input int n);
        case (p)
            0: return 12'd3048;
            1: return 12'(4 * n);
            2: return 12'd4095;
            3: return 12'd0;
            default: return 12'(2048 + (n % 7) - 3);
        endcase
    endfunction

    function automatic logic signed [15:0] pat_cos(input int p, input int n);
        case (p)
            0: return 16'sd1000;
            1: return 16'(((n * 97) % 65536) - 32768);
            2, 3: return 16'sd32767;
            default: return 16'((n % 5) * 3 - 5);
        endcase
    endfunction

    function automatic logic signed [15:0] pat_sin(input int p, input int n);
        case (p)
            0: return -16'sd1000;
            1: return 16'(32767 - ((n * 53) % 65535));
            2, 3: return -16'sd32768;
            default: return 16'(4 - (n % 9));
        endcase
    endfunction

    // Drive one cycle of inputs, then wait for the following falling edge
    task automatic step(input bit st, input bit v, input logic [11:0] c,
                        input logic signed [15:0] co, input logic signed [15:0] si);
        start_i = st; smp_valid_i = v; smp_code_i = c; cos_i = co; sin_i = si;
        @(negedge clk);
        if (done_o) early_done = 1'b1;
    endtask

    task automatic feed(input int p, input int n, input int gap);
        if (gap > 0 && n % gap == gap - 1)
            step(1'b0, 1'b0, 12'hABC, 16'sh7123, -16'sh4321);
        step(1'b0, 1'b1, pat_code(p, n), pat_cos(p, n), pat_sin(p, n));
        sum_re += (longint'(pat_code(p, n)) - 2048) * longint'(pat_cos(p, n));
        sum_im += (longint'(pat_code(p, n)) - 2048) * longint'(pat_sin(p, n));
    endtask

    task automatic run_frame(input int p, input int gap, input string tag);
        sum_re = 0; sum_im = 0; early_done = 1'b0;
        // R7: sample offered alongside start is discarded
        step(1'b1, 1'b1, 12'd4000, 16'sd20000, 16'sd20000);
        check(re_o == 0 && im_o == 0, {"R5 start clears results ", tag}, re_o, 0);
        for (int n = 0; n < FRAME_LEN; n++) feed(p, n, gap);
        check(!early_done && !done_o, {"R1 no done before last edge ", tag}, done_o, 0);
        // R6: valid sample right after the frame is ignored
        step(1'b0, 1'b1, 12'd4095, 16'sd32767, 16'sd32767);
        exp_re = reduce(sum_re); exp_im = reduce(sum_im);
        check(done_o == 1'b1, {"R1 done after last sample ", tag}, done_o, 1);
        check(re_o == exp_re, {"R2 R3 real result ", tag}, re_o, exp_re);
        check(im_o == exp_im, {"R2 R3 imag result ", tag}, im_o, exp_im);
        step(1'b0, 1'b1, 12'd0, -16'sd32768, 16'sd32767);
        check(done_o == 1'b0, {"R4 done single cycle ", tag}, done_o, 0);
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 12'(k * 500), 16'sd9999, -16'sd9999);
        check(re_o == exp_re && im_o == exp_im, {"R5 R6 results held ", tag}, re_o, exp_re);
        check(done_o == 1'b0, {"R6 no done while idle ", tag}, done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(re_o == 0 && im_o == 0, "R8 results zero after reset", re_o, 0);
        check(done_o == 1'b0, "R8 done low after reset", done_o, 0);
        // R6: samples before any start
        early_done = 1'b0;
        for (int k = 0; k < 1100; k++) step(1'b0, 1'b1, 12'd4095, 16'sd32767, 16'sd32767);
        check(!early_done && re_o == 0 && im_o == 0, "R6 unarmed samples ignored", re_o, 0);

        run_frame(0, 0, "constant");
        check(re_o == 15625 && im_o == -15625, "R2 constant known value", re_o, 15625);
        run_frame(1, 3, "ramp with gaps");
        run_frame(2, 0, "full scale high");
        check(re_o == 32767 && im_o == -32768, "R3 clamp both directions high", im_o, -32768);
        run_frame(3, 0, "full scale low");
        check(re_o == -32768 && im_o == 32767, "R3 clamp both directions low", re_o, -32768);
        run_frame(4, 5, "small signal floor");

        // R7: abandon a frame part-way, then restart
        step(1'b1, 1'b0, 12'd0, 16'sd0, 16'sd0);
        early_done = 1'b0;
        for (int n = 0; n < 700; n++) step(1'b0, 1'b1, pat_code(1, n), pat_cos(1, n), pat_sin(1, n));
        check(!early_done, "R7 no done on partial frame", done_o, 0);
        run_frame(0, 2, "restart");
        check(re_o == 15625 && im_o == -15625, "R7 restart uses new frame only", re_o, 15625);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule